// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt sources into two request lines for a processor core: a normal request and a critical request. Each source can be set up on its own. Its polarity says whether the source is active-high or active-low. Its trigger mode says whether it is level-sensitive or edge-capturing. Its enable bit gates whether it can raise a request. Its class bit routes it to the normal line or to the critical line. A status word records which sources are pending. Software reads the status word and acknowledges pending sources through a small word-addressed register bus that has a single-cycle write strobe, a read strobe and combinational read data.

When the vector option is built in, the block also reports a handler address for the highest-priority pending critical source. That address is a programmable base plus a fixed stride times the source's position in the scan. A configuration bit chooses whether the scan starts at the lowest-numbered source or at the highest-numbered one. Both request lines and the vector are registered. Each is due one clock after the status or configuration state that produces it.

Top module: `uicv_top`

## Requirements
- R1: After reset, the following all read as zero: status, enable, class, polarity, trigger, vector configuration and vector. Both request outputs are low.
- R2: Register offsets are as follows. 0 is status (write clears). 1 is status (write sets). 2 is enable. 3 is class (1 = critical). 4 is polarity. 5 is trigger (1 = edge). 6 is masked status. 7 is vector. 8 is vector configuration. Offsets 9 to 15 read as zero, and read data is zero while the read strobe is low.
- R3: A polarity bit of 1 makes its source active-high. A polarity bit of 0 makes it active-low, so the input is inverted before use.
- R4: For a level-mode source, the status bit takes the value of the conditioned input at the next clock edge. It does not change before that edge.
- R5: For an edge-mode source, an inactive-to-active change of the conditioned input sets the status bit at the next clock edge. The bit stays set until software clears it. A source that remains active does not set the bit again.
- R6: A write to offset 0 clears every edge-mode status bit whose data bit is 1. Writes to offsets 0 and 1 leave level-mode status bits unchanged.
- R7: A write to offset 1 sets every edge-mode status bit whose data bit is 1. Reads of offsets 0 and 1 both return the status word.
- R8: When a hardware edge and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: A read of offset 6 returns status AND enable. Writes to offsets 6 and 7 change no register.
- R10: The normal request output equals OR(status AND enable AND NOT class), one clock after that state.
- R11: The critical request output equals OR(status AND enable AND class), one clock after that state.
- R12: A write to offset 8 stores the data with bit 1 forced to 0. Bit 0 of the stored value selects the scan: 0 scans upward from source 0, and 1 scans downward from source 31.
- R13: While a critical source is pending, the vector equals the configuration with its two low bits cleared, plus 512 times the position of the first pending critical source in scan order. Otherwise the vector is zero. Sources in the normal class never affect it. Its timing matches R11.
- R14: With the vector option disabled, offsets 7 and 8 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt source lines |
| bus_addr | input | ADDR_W | Word offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when not reading |
| irq_o | output | 1 | Normal interrupt request |
| cirq_o | output | 1 | Critical interrupt request |

## Verification
A source change presented between edges shows in the status word just after the next rising edge. A register write does the same for the configuration it targets and for the status bits it clears or sets. The request lines and the vector trail that state by one more edge. The bench therefore changes inputs at the falling edge and reads status at the following falling edge. It waits one further falling edge before it compares the request lines or reads the vector. A single read made mid-cycle, before any edge, confirms that level-mode status has not moved before its edge. The vector sweep walks every source position in both scan directions and computes each expected address arithmetically.

// File: rtl/uicv_pkg.sv
package uicv_pkg;
   // Word offsets of the register bus; the sequence is the programming model.
   localparam int unsigned OFS_STAT = 0;
   localparam int unsigned OFS_SET  = 1;
   localparam int unsigned OFS_EN   = 2;
   localparam int unsigned OFS_CRIT = 3;
   localparam int unsigned OFS_POL  = 4;
   localparam int unsigned OFS_TRIG = 5;
   localparam int unsigned OFS_MSK  = 6;
   localparam int unsigned OFS_VEC  = 7;
   localparam int unsigned OFS_VCFG = 8;
   localparam int unsigned MIN_ADDR_W = 4;
endpackage

// File: rtl/uicv_regs.sv
module uicv_regs
   import uicv_pkg::*;
#(
   parameter int unsigned N_SRC   = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          HAS_VEC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [N_SRC-1:0]  en_o,
   output logic [N_SRC-1:0]  crit_o,
   output logic [N_SRC-1:0]  pol_o,
   output logic [N_SRC-1:0]  trig_o,
   output logic [DATA_W-1:0] vcfg_o,
   output logic [N_SRC-1:0]  sw_clr_o,
   output logic [N_SRC-1:0]  sw_set_o
);
   localparam logic [DATA_W-1:0] VCFG_KEEP = ~DATA_W'(2);

   logic hit_stat, hit_set, hit_en, hit_crit, hit_pol, hit_trig, hit_vcfg;

   assign hit_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_set  = bus_wr && (bus_addr == ADDR_W'(OFS_SET));
   assign hit_en   = bus_wr && (bus_addr == ADDR_W'(OFS_EN));
   assign hit_crit = bus_wr && (bus_addr == ADDR_W'(OFS_CRIT));
   assign hit_pol  = bus_wr && (bus_addr == ADDR_W'(OFS_POL));
   assign hit_trig = bus_wr && (bus_addr == ADDR_W'(OFS_TRIG));
   assign hit_vcfg = bus_wr && (bus_addr == ADDR_W'(OFS_VCFG));

   assign sw_clr_o = hit_stat ? bus_wdata[N_SRC-1:0] : '0;
   assign sw_set_o = hit_set  ? bus_wdata[N_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= '0;
         crit_o <= '0;
         pol_o  <= '0;
         trig_o <= '0;
      end else begin
         if (hit_en)   en_o   <= bus_wdata[N_SRC-1:0];
         if (hit_crit) crit_o <= bus_wdata[N_SRC-1:0];
         if (hit_pol)  pol_o  <= bus_wdata[N_SRC-1:0];
         if (hit_trig) trig_o <= bus_wdata[N_SRC-1:0];
      end
   end

   generate
      if (HAS_VEC) begin : g_vcfg
         logic [DATA_W-1:0] vcfg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        vcfg_q <= '0;
            else if (hit_vcfg) vcfg_q <= bus_wdata & VCFG_KEEP;
         end
         assign vcfg_o = vcfg_q;
      end else begin : g_no_vcfg
         logic unused_vcfg_hit;
         assign unused_vcfg_hit = hit_vcfg;
         assign vcfg_o = '0;
      end
   endgenerate
endmodule

// File: rtl/uicv_status.sv
module uicv_status #(
   parameter int unsigned N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   input  logic [N_SRC-1:0] pol_i,
   input  logic [N_SRC-1:0] trig_i,
   input  logic [N_SRC-1:0] sw_clr_i,
   input  logic [N_SRC-1:0] sw_set_i,
   output logic [N_SRC-1:0] status_o
);
   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_src
         logic act, act_prev_q, stat_q, rise;

         // Active-high when the polarity bit is 1, inverted otherwise.
         assign act  = pol_i[g] ? src_i[g] : ~src_i[g];
         assign rise = act & ~act_prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_prev_q <= 1'b0;
               stat_q     <= 1'b0;
            end else begin
               act_prev_q <= act;
               if (trig_i[g])
                  // Set sources are ORed after the clear, so a set wins.
                  stat_q <= rise | sw_set_i[g] | (stat_q & ~sw_clr_i[g]);
               else
                  stat_q <= act;
            end
         end

         assign status_o[g] = stat_q;
      end
   endgenerate
endmodule

// File: rtl/uicv_vector.sv
module uicv_vector #(
   parameter int unsigned N_SRC       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned STRIDE_LOG2 = 9,
   parameter bit          HAS_VEC     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  cpend_i,
   input  logic [DATA_W-1:0] vcfg_i,
   output logic [DATA_W-1:0] vec_o
);
   localparam int unsigned PW = $clog2(N_SRC);
   localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'(3);

   generate
      if (HAS_VEC) begin : g_vec
         logic          found;
         logic [PW-1:0] pos_d;
         logic [DATA_W-1:0] vec_d, vec_q;

         always_comb begin
            found = 1'b0;
            pos_d = '0;
            for (int i = 0; i < N_SRC; i++) begin
               int unsigned idx;
               idx = vcfg_i[0] ? (N_SRC - 1 - i) : i;
               if (!found && cpend_i[idx[PW-1:0]]) begin
                  found = 1'b1;
                  pos_d = PW'(i);
               end
            end
            vec_d = found ? ((vcfg_i & BASE_MASK) + (DATA_W'(pos_d) << STRIDE_LOG2))
                          : '0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vec_q <= '0;
            else        vec_q <= vec_d;
         end
         assign vec_o = vec_q;
      end else begin : g_no_vec
         logic unused_vec_in;
         assign unused_vec_in = ^{clk, rst_n, cpend_i, vcfg_i};
         assign vec_o = '0;
      end
   endgenerate
endmodule

// File: rtl/uicv_top.sv
module uicv_top
   import uicv_pkg::*;
#(
   parameter int unsigned N_SRC       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned STRIDE_LOG2 = 9,
   parameter bit          HAS_VEC     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              cirq_o
);
   generate
      if (N_SRC < 2 || N_SRC > DATA_W) begin : g_bad_src
         $error("uicv_top: N_SRC must lie in 2..DATA_W");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("uicv_top: ADDR_W too narrow for the register map");
      end
      if (HAS_VEC && (STRIDE_LOG2 + $clog2(N_SRC) > DATA_W)) begin : g_bad_stride
         $error("uicv_top: vector offset exceeds DATA_W");
      end
   endgenerate

   logic [N_SRC-1:0]  en_q, crit_q, pol_q, trig_q, sw_clr, sw_set, status_q;
   logic [N_SRC-1:0]  npend, cpend;
   logic [DATA_W-1:0] vcfg_q, vec_q;
   logic              irq_q, cirq_q;

   uicv_regs #(
      .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAS_VEC(HAS_VEC)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .en_o(en_q), .crit_o(crit_q), .pol_o(pol_q),
      .trig_o(trig_q), .vcfg_o(vcfg_q), .sw_clr_o(sw_clr), .sw_set_o(sw_set)
   );

   uicv_status #(.N_SRC(N_SRC)) status_i (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .pol_i(pol_q), .trig_i(trig_q),
      .sw_clr_i(sw_clr), .sw_set_i(sw_set), .status_o(status_q)
   );

   assign npend = status_q & en_q & ~crit_q;
   assign cpend = status_q & en_q & crit_q;

   uicv_vector #(
      .N_SRC(N_SRC), .DATA_W(DATA_W), .STRIDE_LOG2(STRIDE_LOG2), .HAS_VEC(HAS_VEC)
   ) vector_i (
      .clk(clk), .rst_n(rst_n), .cpend_i(cpend), .vcfg_i(vcfg_q), .vec_o(vec_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         cirq_q <= 1'b0;
      end else begin
         irq_q  <= |npend;
         cirq_q <= |cpend;
      end
   end

   assign irq_o  = irq_q;
   assign cirq_o = cirq_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            ADDR_W'(OFS_STAT), ADDR_W'(OFS_SET): bus_rdata = DATA_W'(status_q);
            ADDR_W'(OFS_EN):   bus_rdata = DATA_W'(en_q);
            ADDR_W'(OFS_CRIT): bus_rdata = DATA_W'(crit_q);
            ADDR_W'(OFS_POL):  bus_rdata = DATA_W'(pol_q);
            ADDR_W'(OFS_TRIG): bus_rdata = DATA_W'(trig_q);
            ADDR_W'(OFS_MSK):  bus_rdata = DATA_W'(status_q & en_q);
            ADDR_W'(OFS_VEC):  bus_rdata = vec_q;
            ADDR_W'(OFS_VCFG): bus_rdata = vcfg_q;
            default:           bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/uicv_chk.sv
module uicv_chk
   import uicv_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [N_SRC-1:0]  wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [N_SRC-1:0]  status,
   input logic [N_SRC-1:0]  en,
   input logic [N_SRC-1:0]  crit,
   input logic [N_SRC-1:0]  trig,
   input logic              vcfg_b1,
   input logic [DATA_W-1:0] vec,
   input logic              irq_o,
   input logic              cirq_o
);
   logic [N_SRC-1:0] clr_req, set_req;
   assign clr_req = (bus_wr && bus_addr == ADDR_W'(OFS_STAT)) ? wdata : '0;
   assign set_req = (bus_wr && bus_addr == ADDR_W'(OFS_SET))  ? wdata : '0;

   AST_NORM_OUT:  assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(|(status & en & ~crit)));                      // R10
   AST_CRIT_OUT:  assert property (@(posedge clk) disable iff (!rst_n)
      cirq_o == $past(|(status & en & crit)));                      // R11
   AST_VEC_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
      !cirq_o |-> (vec == '0));                                     // R13
   AST_VCFG_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
      vcfg_b1 == 1'b0);                                             // R12
   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status & trig & ~clr_req) & ~status) == '0);           // R5
   AST_SW_SET:    assert property (@(posedge clk) disable iff (!rst_n)
      ($past(set_req & trig) & ~status) == '0);                     // R7
   AST_RD_IDLE:   assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (rdata == '0));                                   // R2
endmodule

bind uicv_top uicv_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .wdata(bus_wdata[N_SRC-1:0]), .rdata(bus_rdata), .status(status_q), .en(en_q),
   .crit(crit_q), .trig(trig_q), .vcfg_b1(vcfg_q[1]), .vec(vec_q),
   .irq_o(irq_o), .cirq_o(cirq_o)
);

// File: tb/uicv_top_tb_top.sv
`timescale 1ns/1ps
module uicv_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] src;
   logic [3:0]  bus_addr;
   logic        bus_wr, bus_rd;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata, rdata_nv;
   logic        irq, cirq, irq_nv, cirq_nv;
   logic [31:0] rd_val, rd_nv;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   uicv_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq), .cirq_o(cirq)
   );

   uicv_top #(.HAS_VEC(1'b0)) dut_nv_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_nv),
      .irq_o(irq_nv), .cirq_o(cirq_nv)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a[3:0];
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input int a);
      bus_addr = a[3:0];
      bus_rd   = 1'b1;
      #1;
      rd_val   = bus_rdata;
      rd_nv    = rdata_nv;
      bus_rd   = 1'b0;
   endtask

   task automatic rchk(input string req, input int a, input logic [31:0] exp);
      rd(a);
      chk(req, rd_val, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] s, e, c, base, exp_st;
      rst_n = 1'b0; src = '1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state, R2 unmapped offsets
      for (int a = 0; a < 9; a++) rchk("R1 reset register", a, 32'h0);
      for (int a = 9; a < 16; a++) rchk("R2 unmapped offset", a, 32'h0);
      chk("R1 reset irq", {31'b0, irq}, 32'h0);
      chk("R1 reset cirq", {31'b0, cirq}, 32'h0);
      chk("R2 idle rdata", bus_rdata, 32'h0);

      // R2 readback of configuration, R9 ignored writes
      wr(2, 32'hA5A5_0F0F); wr(3, 32'h3C3C_00FF); wr(4, 32'h1234_FFFF); wr(5, 32'h0000_0000);
      rchk("R2 enable", 2, 32'hA5A5_0F0F);
      rchk("R2 class", 3, 32'h3C3C_00FF);
      rchk("R2 polarity", 4, 32'h1234_FFFF);
      rchk("R2 trigger", 5, 32'h0);
      wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
      rchk("R9 enable kept", 2, 32'hA5A5_0F0F);
      rchk("R9 class kept", 3, 32'h3C3C_00FF);
      rchk("R9 polarity kept", 4, 32'h1234_FFFF);
      rchk("R9 vector kept", 7, 32'h0);
      wr(2, 0); wr(3, 0); wr(5, 0);

      // R3/R4 level mode, polarity sweep
      for (int p = 0; p < 2; p++) begin
         wr(4, p ? 32'hFFFF_FFFF : 32'h0);
         for (int i = 0; i < 32; i++) begin
            src = 32'h1 << i;
            tick();
            rchk("R3 polarity", 0, p ? (32'h1 << i) : ~(32'h1 << i));
         end
      end
      wr(4, 32'h0000_FFFF);
      src = 32'h00FF_00FF;
      tick();
      rchk("R3 mixed polarity", 0, ~(32'h00FF_00FF ^ 32'h0000_FFFF));
      wr(4, 32'hFFFF_FFFF);
      src = 32'h0000_00F0;
      tick();
      src = 32'h0000_0F00;
      #0.5;
      rchk("R4 no change before edge", 0, 32'h0000_00F0);
      tick();
      rchk("R4 follows after edge", 0, 32'h0000_0F00);
      wr(0, 32'hFFFF_FFFF);
      rchk("R6 level ignores clear", 0, 32'h0000_0F00);
      src = 32'h0;
      wr(1, 32'hFFFF_FFFF);
      rchk("R6 level ignores set", 0, 32'h0);

      // R5 edge capture sweep
      wr(5, 32'hFFFF_FFFF);
      wr(0, 32'hFFFF_FFFF);
      rchk("R5 cleared start", 0, 32'h0);
      exp_st = 32'h0;
      for (int i = 0; i < 32; i++) begin
         src = 32'h1 << i;
         tick();
         src = 32'h0;
         tick();
         exp_st |= 32'h1 << i;
         rchk("R5 edge sticky", 0, exp_st);
      end
      wr(0, 32'h0000_FFFF);
      rchk("R6 clear low half", 0, 32'hFFFF_0000);
      wr(1, 32'h0000_0101);
      rchk("R7 set via offset 0 read", 0, 32'hFFFF_0101);
      rchk("R7 set via offset 1 read", 1, 32'hFFFF_0101);
      wr(0, 32'hFFFF_FFFF);
      src = 32'h20;
      tick();
      rchk("R5 rising sets", 0, 32'h20);
      wr(0, 32'h20);
      tick(); tick();
      rchk("R5 held level no reset", 0, 32'h0);
      src = 32'h0;
      tick();

      // R8 set wins over clear
      @(negedge clk);
      src = 32'h8; bus_addr = 4'd0; bus_wdata = 32'h8; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rchk("R8 set wins", 0, 32'h8);
      src = 32'h0;
      wr(0, 32'hFFFF_FFFF);

      // R9 masked status, R10/R11 request outputs
      for (int k = 0; k < 8; k++) begin
         s = 32'h1 << (k * 4 + 1);
         e = k[0] ? 32'hFFFF_FFFF : 32'h5555_5555;
         c = k[1] ? 32'hFFFF_0000 : 32'h0;
         wr(0, 32'hFFFF_FFFF); wr(2, e); wr(3, c); wr(1, s);
         rchk("R9 masked status", 6, s & e);
         tick();
         chk("R10 normal request", {31'b0, irq}, {31'b0, |(s & e & ~c)});
         chk("R11 critical request", {31'b0, cirq}, {31'b0, |(s & e & c)});
      end

      // R12/R13 vector sweep in both scan directions
      wr(0, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
      base = 32'h1234_5600;
      for (int d = 0; d < 2; d++) begin
         wr(8, base | 32'h2 | d);
         rchk("R12 config bit1 forced", 8, base | d);
         for (int i = 0; i < 32; i++) begin
            wr(0, 32'hFFFF_FFFF);
            wr(1, d ? (32'hFFFF_FFFF >> (31 - i)) : (32'hFFFF_FFFF << i));
            tick();
            rchk("R13 vector value", 7, base + (d ? (31 - i) : i) * 512);
            chk("R11 critical with vector", {31'b0, cirq}, 32'h1);
         end
         wr(7, 32'h0);
         rchk("R9 vector write ignored", 7, base + (d ? 0 : 31) * 512);
         wr(0, 32'hFFFF_FFFF);
         tick();
         rchk("R13 vector idle", 7, 32'h0);
      end
      wr(3, 32'h0000_FFFF);
      wr(1, 32'hFFFF_FFFF);
      tick();
      rchk("R13 normal class ignored", 7, base + 16 * 512 + 0);

      // R14 vector option removed
      rd(8);
      chk("R14 no config register", rd_nv, 32'h0);
      rd(7);
      chk("R14 no vector register", rd_nv, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule